// File: doc/BRIEF.md
# Watchdog External Reset Pulse Shaper

This block turns a watchdog expiry event into a timed reset pulse on an external pin. When the expiry input fires and the external-signal enable is high, the block asserts its pin for a programmed number of microseconds. It then returns the pin to the inactive level. The microsecond time base comes from a prescaler on the system clock. The prescaler restarts with every trigger, so each pulse lasts a whole number of microseconds.

One 32-bit configuration word sits on a simple register bus. The low field holds the pulse width. A value N in that field gives a pulse of N+1 microseconds. The top byte carries key values, and only the four defined keys can change the pin polarity or the drive style. Any other top byte still updates the width but leaves both flags as they were. The pin comes out as a value and an output-enable, which lets the pad stage model either push-pull drive or open-drain drive.

Top module: `ext_reset_pulser`

## Requirements
- R1: The width field is bits WIDTH_BITS-1:0 of the configuration word (20 bits by default, 8 in the narrow variant). A write updates it from the matching write-data bits. Bits above the field, other than 31 and 30, always read as 0.
- R2: A width value N gives a pin pulse that lasts (N+1)*CLKS_PER_US clock cycles, so N=0 gives one microsecond.
- R3: After reset the configuration reads 0x000000FF: width 255, active-low, open-drain. The pin is idle high with the output-enable low.
- R4: Writing top byte 0xA5 selects active-high and 0x5A selects active-low. Polarity reads back in bit 31, where 1 means active-high.
- R5: Writing top byte 0xA8 selects push-pull and 0x8A selects open-drain. Drive mode reads back in bit 30, where 1 means push-pull.
- R6: A write with any other top byte leaves the polarity and drive bits unchanged and still updates the width.
- R7: An expiry event with the external-signal enable low produces no pulse.
- R8: An expiry event during a pulse restarts the full duration from that event.
- R9: The pin rests at the inactive level. In open-drain mode the output-enable is high only while the pulse is asserted. In push-pull mode it stays high.
- R10: The configuration lives at offset CFG_ADDR (0x18). Reads of any other offset return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears one cycle later |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_expire | input | 1 | One-cycle watchdog expiry event |
| ext_en | input | 1 | External-signal enable |
| rst_pin | output | 1 | Reset pin value |
| rst_oe | output | 1 | Reset pin output-enable |

## Verification
The bench writes configuration words that cover every key byte, several non-key top bytes and widths from 0 up to the reset value. After each write it measures the asserted pulse length at the pins. The length checks separate an off-by-one in the width from a prescaler that fails to restart. The readback and idle-level checks separate key decoding from width updating. Directed runs cover a disabled trigger, a retrigger in mid-pulse and a write to a foreign offset.

// File: rtl/ext_reset_pkg.sv
package ext_reset_pkg;
  localparam logic [7:0] KEY_POL_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW   = 8'h5A;
  localparam logic [7:0] KEY_DRV_PUSH  = 8'hA8;
  localparam logic [7:0] KEY_DRV_OPEN  = 8'h8A;
  localparam int         POL_BIT       = 31;
  localparam int         DRV_BIT       = 30;
  localparam int         WIDTH_RESET   = 255;

  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_POL  = 2'd1,
    KEY_DRV  = 2'd2
  } key_kind_e;
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int CLKS_PER_US = 50,
  localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/ext_reset_cfg.sv
module ext_reset_cfg
  import ext_reset_pkg::*;
#(
  parameter int WIDTH_BITS = 20,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8'h18)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  cfg_pol,
  output logic                  cfg_pp,
  output logic [WIDTH_BITS-1:0] cfg_width
);
  logic       hit_wr;
  logic [7:0] top;
  key_kind_e  kind;
  logic       key_val;
  logic [31:0] rb;

  assign hit_wr = bus_we && (bus_addr == CFG_ADDR);
  assign top    = bus_wdata[31:24];

  always_comb begin
    kind    = KEY_NONE;
    key_val = 1'b0;
    case (top)
      KEY_POL_HIGH: begin kind = KEY_POL; key_val = 1'b1; end
      KEY_POL_LOW:  begin kind = KEY_POL; key_val = 1'b0; end
      KEY_DRV_PUSH: begin kind = KEY_DRV; key_val = 1'b1; end
      KEY_DRV_OPEN: begin kind = KEY_DRV; key_val = 1'b0; end
      default:      begin kind = KEY_NONE; key_val = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pol   <= 1'b0;
      cfg_pp    <= 1'b0;
      cfg_width <= WIDTH_BITS'(WIDTH_RESET);
    end else if (hit_wr) begin
      cfg_width <= bus_wdata[WIDTH_BITS-1:0];
      if (kind == KEY_POL) cfg_pol <= key_val;
      if (kind == KEY_DRV) cfg_pp  <= key_val;
    end
  end

  always_comb begin
    rb                   = '0;
    rb[WIDTH_BITS-1:0]   = cfg_width;
    rb[POL_BIT]          = cfg_pol;
    rb[DRV_BIT]          = cfg_pp;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= (bus_addr == CFG_ADDR) ? rb : 32'd0;
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int WIDTH_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig,
  input  logic                  tick,
  input  logic [WIDTH_BITS-1:0] width,
  output logic                  active
);
  logic [WIDTH_BITS-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      remain_q <= '0;
    end else if (trig) begin
      active   <= 1'b1;
      remain_q <= width;
    end else if (active && tick) begin
      if (remain_q == '0) active <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/pin_driver.sv
module pin_driver (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pol_high,
  input  logic push_pull,
  output logic pin,
  output logic oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b1;
      oe  <= 1'b0;
    end else begin
      pin <= active ? pol_high : ~pol_high;
      oe  <= push_pull | active;
    end
  end
endmodule

// File: rtl/ext_reset_pulser.sv
module ext_reset_pulser #(
  parameter int WIDTH_BITS  = 20,
  parameter int CLKS_PER_US = 50,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8'h18)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wdt_expire,
  input  logic              ext_en,
  output logic              rst_pin,
  output logic              rst_oe
);
  logic                  cfg_pol;
  logic                  cfg_pp;
  logic [WIDTH_BITS-1:0] cfg_width;
  logic                  trig;
  logic                  tick;
  logic                  pulse_active;

  assign trig = wdt_expire && ext_en;

  ext_reset_cfg #(
    .WIDTH_BITS(WIDTH_BITS), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
  ) u_cfg (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_pol(cfg_pol), .cfg_pp(cfg_pp), .cfg_width(cfg_width)
  );

  us_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
    .clk(clk), .rst(rst), .restart(trig), .run(pulse_active), .tick(tick)
  );

  pulse_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
    .clk(clk), .rst(rst), .trig(trig), .tick(tick),
    .width(cfg_width), .active(pulse_active)
  );

  pin_driver u_drv (
    .clk(clk), .rst(rst), .active(pulse_active), .pol_high(cfg_pol),
    .push_pull(cfg_pp), .pin(rst_pin), .oe(rst_oe)
  );
endmodule

// File: rtl/ext_reset_pulser_chk.sv
module ext_reset_pulser_chk #(
  parameter int WIDTH_BITS = 20,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8'h18)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  wdt_expire,
  input logic                  ext_en,
  input logic                  rst_oe,
  input logic                  cfg_pol,
  input logic                  cfg_pp,
  input logic [WIDTH_BITS-1:0] cfg_width,
  input logic                  pulse_active
);
  logic cfg_hit;
  assign cfg_hit = bus_we && (bus_addr == CFG_ADDR);

  // R9: push-pull keeps the output-enable high
  a_r9_pp_oe: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_pp) |-> rst_oe);

  // R9: open-drain releases the pin when no pulse runs
  a_r9_od_release: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pp && !pulse_active) |=> !rst_oe);

  // R7: nothing starts a pulse except an enabled expiry
  a_r7_no_start: assert property (@(posedge clk) disable iff (rst)
    (!pulse_active && !(wdt_expire && ext_en)) |=> !pulse_active);

  // R8: an enabled expiry always leaves a pulse running
  a_r8_trig_active: assert property (@(posedge clk) disable iff (rst)
    (wdt_expire && ext_en) |=> pulse_active);

  // R6: non-key top byte keeps polarity
  a_r6_pol_kept: assert property (@(posedge clk) disable iff (rst)
    (cfg_hit && bus_wdata[31:24] != 8'hA5 && bus_wdata[31:24] != 8'h5A)
    |=> $stable(cfg_pol));

  // R6: non-key top byte keeps drive mode
  a_r6_drv_kept: assert property (@(posedge clk) disable iff (rst)
    (cfg_hit && bus_wdata[31:24] != 8'hA8 && bus_wdata[31:24] != 8'h8A)
    |=> $stable(cfg_pp));

  // R10: foreign offsets leave the width alone
  a_r10_other_addr: assert property (@(posedge clk) disable iff (rst)
    (!cfg_hit) |=> $stable(cfg_width));
endmodule

bind ext_reset_pulser ext_reset_pulser_chk #(
  .WIDTH_BITS(WIDTH_BITS), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wdt_expire(wdt_expire), .ext_en(ext_en),
  .rst_oe(rst_oe), .cfg_pol(cfg_pol), .cfg_pp(cfg_pp),
  .cfg_width(cfg_width), .pulse_active(pulse_active)
);

// File: tb/tb_ext_reset_pulser.sv
module tb_ext_reset_pulser;
  localparam int CPU = 4;
  localparam int NV  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_addr = 8'h18;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_expire = 1'b0;
  logic        ext_en = 1'b1;
  logic        rst_pin;
  logic        rst_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ext_reset_pulser #(.WIDTH_BITS(20), .CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_expire(wdt_expire), .ext_en(ext_en),
    .rst_pin(rst_pin), .rst_oe(rst_oe)
  );

  // write word, expected readback, expected width+1 in microseconds
  localparam logic [31:0] VW [NV] = '{32'hA500_0003, 32'hA800_0000,
    32'h1200_0007, 32'h5A00_0001, 32'h8A00_000A, 32'hFFF0_0002};
  localparam logic [31:0] VR [NV] = '{32'h8000_0003, 32'hC000_0000,
    32'hC000_0007, 32'h4000_0001, 32'h0000_000A, 32'h0000_0002};
  localparam int VL [NV] = '{4, 1, 8, 2, 11, 3};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  // fire an expiry, optionally again at cycle retrig, count asserted samples
  task automatic measure(input logic pol, input int retrig, input int window, output int n);
    n = 0;
    for (int t = 0; t < window; t++) begin
      @(negedge clk);
      if (oe_asserted(pol)) n++;
      wdt_expire = (t == 0) || (retrig > 0 && t == retrig);
    end
    wdt_expire = 1'b0;
  endtask

  function automatic logic oe_asserted(input logic pol);
    return rst_oe && (rst_pin == pol);
  endfunction

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3 reset state
    chk("R3 idle pin", {31'd0, rst_pin}, 32'd1);
    chk("R3 idle oe", {31'd0, rst_oe}, 32'd0);
    rd(8'h18, d);
    chk("R3 reset readback", d, 32'h0000_00FF);
    measure(1'b0, 0, 256 * CPU + 30, n);
    chk("R2 R3 default pulse length", n, 256 * CPU);

    // table walk: R1 R4 R5 R6 readback, R2 length, R9 levels
    for (int i = 0; i < NV; i++) begin
      wr(8'h18, VW[i]);
      rd(8'h18, d);
      chk("R1 R4 R5 R6 readback", d, VR[i]);
      chk("R9 idle pin", {31'd0, rst_pin}, {31'd0, ~VR[i][31]});
      chk("R9 idle oe", {31'd0, rst_oe}, {31'd0, VR[i][30]});
      measure(VR[i][31], 0, VL[i] * CPU + 30, n);
      chk("R2 pulse length", n, VL[i] * CPU);
    end

    // R7: disabled external signal
    ext_en = 1'b0;
    measure(1'b0, 0, 40, n);
    chk("R7 no pulse when disabled", n, 0);
    ext_en = 1'b1;

    // R8: retrigger after 10 cycles of an 8 us pulse
    wr(8'h18, 32'h0000_0007);
    measure(1'b0, 10, 8 * CPU + 40, n);
    chk("R8 retrigger length", n, 10 + 8 * CPU);

    // R9: push-pull active-high, pin driven during pulse too
    wr(8'h18, 32'hA800_0001);
    wr(8'h18, 32'hA500_0001);
    measure(1'b1, 0, 2 * CPU + 20, n);
    chk("R9 push-pull active-high length", n, 2 * CPU);
    chk("R9 push-pull oe after pulse", {31'd0, rst_oe}, 32'd1);

    // R10: foreign offset
    wr(8'h1C, 32'h5A00_0009);
    rd(8'h18, d);
    chk("R10 config untouched", d, 32'hC000_0001);
    rd(8'h1C, d);
    chk("R10 other offset reads zero", d, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule